// File: doc/BRIEF.md
# Phase-Accumulating Sine Synthesizer

This block is a numerically controlled oscillator for direct digital synthesis. A wide phase register advances on every clock by a stored frequency word. The output frequency is therefore `f_clk * word / 2^PHASE_W`. If the clock is a power of two in hertz, for example 2^22 Hz with a 24-bit phase, each step of the word is an exact binary fraction of a hertz (0.25 Hz in that case).

The upper phase bits index a sine table. The table entry is registered and presented as an unsigned sample for an external converter. Alongside the table, the uppermost three phase bits are decoded into eight one-hot lines, also registered. These lines can switch an external resistor ladder to give a coarse stepped waveform.

A host loads the frequency word through a parallel port qualified by a write strobe. Loading a word does not disturb the phase, so the waveform stays continuous across retuning. Words above the usable limit of 2/5 of the phase range (clock divided by 2.5) are clamped to that limit. The phase register is also brought out on a port, so the accumulation can be observed.

Top module: `dds_sine_gen`

## Requirements
- R1: With `rst` high at a clock edge, the phase register and the stored word become zero, `sample_out` becomes 128 and `seg_out` becomes 8'b0000_0001. While no word is written, these values hold after reset.
- R2: On each clock edge without reset, `phase_out` becomes its previous value plus the stored word, modulo 2^PHASE_W. After N edges from phase zero with a constant word W, the phase equals N·W mod 2^PHASE_W.
- R3: When `ftw_wr` is high at an edge, `ftw_in` is stored at that edge. The stored word is first added at the following edge. The phase is never reset by a write.
- R4: A written word greater than floor(2·2^PHASE_W/5) is stored as that limit. The limit is 6710886 for a 24-bit phase. A word equal to the limit is stored unchanged.
- R5: At each edge without reset, `sample_out` takes 128 + round(127·sin(2πa/256)), where a is bits [PHASE_W-1:PHASE_W-8] of the phase value held before that edge. Rounding is half away from zero.
- R6: At each edge without reset, `seg_out` becomes one-hot. The bit that is set has the index given by bits [PHASE_W-1:PHASE_W-3] of the phase held before that edge.
- R7: The phase wraps past 2^PHASE_W - 1 without stopping or saturating.
- R8: While `ftw_wr` is low, `ftw_in` has no effect on the stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Accumulator clock |
| rst | input | 1 | Synchronous reset, active high |
| ftw_wr | input | 1 | Write strobe for the frequency word |
| ftw_in | input | PHASE_W | Frequency word from the host |
| phase_out | output | PHASE_W | Current phase register |
| sample_out | output | SAMPLE_W | Unsigned sine sample for the converter |
| seg_out | output | 8 | One-hot decode of the top three phase bits |

## Verification
The phase is due one edge after the word it adds, and a newly written word first shows in the phase one edge after the write edge. The sample and one-hot outputs follow the phase that was held before the edge, so they lag the phase port by one clock. The bench keeps its own model of the phase and the stored word and advances it at every rising edge, exactly as the requirements describe. It queues the expected phase, sample and segment for that edge, and a monitor compares them at the next falling edge. Each expected sample and segment is derived from the model phase of the previous cycle, never from the current one.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam real TWO_PI = 6.283185307179586;

    // Offset-binary sine code for table slot k of a 2^aw table, dw bits wide.
    function automatic int sine_code(input int k, input int aw, input int dw);
        real amp;
        real v;
        int  mid;
        mid = 1 << (dw - 1);
        amp = real'(mid - 1);
        v   = amp * $sin(TWO_PI * real'(k) / real'(1 << aw));
        if (v >= 0.0)
            return mid + $rtoi(v + 0.5);
        else
            return mid - $rtoi(0.5 - v);
    endfunction

    // Largest usable word: phase range times 2/5 (clock over 2.5).
    function automatic longint word_limit(input int pw);
        return ((longint'(1) << pw) * 2) / 5;
    endfunction

endpackage

// File: rtl/dds_phase_accum.sv
module dds_phase_accum #(
    parameter int PHASE_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [PHASE_W-1:0] word_in,
    output logic [PHASE_W-1:0] phase_q,
    output logic [PHASE_W-1:0] word_q
);
    localparam logic [PHASE_W-1:0] LIMIT = PHASE_W'(dds_pkg::word_limit(PHASE_W));

    logic [PHASE_W-1:0] word_lim;

    always_comb begin
        word_lim = (word_in > LIMIT) ? LIMIT : word_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            word_q  <= '0;
        end else begin
            phase_q <= phase_q + word_q;
            if (wr) begin
                word_q <= word_lim;
            end
        end
    end
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] sample_q
);
    localparam int              DEPTH = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] MID = DATA_W'(1 << (DATA_W - 1));

    logic [DATA_W-1:0] rom [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        localparam logic [DATA_W-1:0] CODE = DATA_W'(dds_pkg::sine_code(k, ADDR_W, DATA_W));
        assign rom[k] = CODE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= MID;
        end else begin
            sample_q <= rom[addr];
        end
    end
endmodule

// File: rtl/dds_coarse_decoder.sv
module dds_coarse_decoder #(
    parameter int SEL_W = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SEL_W-1:0]       sel,
    output logic [(1<<SEL_W)-1:0]  lines_q
);
    localparam int LINES = 1 << SEL_W;

    logic [LINES-1:0] lines_d;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign lines_d[i] = (sel == SEL_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lines_q <= LINES'(1);
        end else begin
            lines_q <= lines_d;
        end
    end
endmodule

// File: rtl/dds_sine_gen.sv
module dds_sine_gen #(
    parameter int PHASE_W  = 24,
    parameter int LUT_AW   = 8,
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ftw_wr,
    input  logic [PHASE_W-1:0]  ftw_in,
    output logic [PHASE_W-1:0]  phase_out,
    output logic [SAMPLE_W-1:0] sample_out,
    output logic [7:0]          seg_out
);
    localparam int SEG_SEL_W = 3;

    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] ftw_q;

    dds_phase_accum #(.PHASE_W(PHASE_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .wr      (ftw_wr),
        .word_in (ftw_in),
        .phase_q (phase_q),
        .word_q  (ftw_q)
    );

    dds_sine_rom #(.ADDR_W(LUT_AW), .DATA_W(SAMPLE_W)) u_rom (
        .clk      (clk),
        .rst      (rst),
        .addr     (phase_q[PHASE_W-1 -: LUT_AW]),
        .sample_q (sample_out)
    );

    dds_coarse_decoder #(.SEL_W(SEG_SEL_W)) u_seg (
        .clk     (clk),
        .rst     (rst),
        .sel     (phase_q[PHASE_W-1 -: SEG_SEL_W]),
        .lines_q (seg_out)
    );

    assign phase_out = phase_q;
endmodule

// File: rtl/dds_sine_gen_chk.sv
module dds_sine_gen_chk #(
    parameter int PHASE_W  = 24,
    parameter int SAMPLE_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                ftw_wr,
    input logic [PHASE_W-1:0]  ftw_in,
    input logic [PHASE_W-1:0]  phase_out,
    input logic [SAMPLE_W-1:0] sample_out,
    input logic [7:0]          seg_out,
    input logic [PHASE_W-1:0]  ftw_q
);
    localparam logic [PHASE_W-1:0]  LIMIT = PHASE_W'(dds_pkg::word_limit(PHASE_W));
    localparam logic [SAMPLE_W-1:0] MID   = SAMPLE_W'(1 << (SAMPLE_W - 1));

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (phase_out == '0 && ftw_q == '0 && sample_out == MID && seg_out == 8'd1));

    assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> phase_out == PHASE_W'($past(phase_out) + $past(ftw_q)));

    assert_word_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ftw_wr)) |->
            ftw_q == (($past(ftw_in) > LIMIT) ? LIMIT : $past(ftw_in)));

    assert_word_limit_R4: assert property (@(posedge clk) disable iff (rst)
        ftw_q <= LIMIT);

    assert_seg_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(seg_out) == 1);

    assert_seg_tracks_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> seg_out[$past(phase_out[PHASE_W-1 -: 3])]);

    assert_word_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ftw_wr)) |-> $stable(ftw_q));
endmodule

bind dds_sine_gen dds_sine_gen_chk #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ftw_wr     (ftw_wr),
    .ftw_in     (ftw_in),
    .phase_out  (phase_out),
    .sample_out (sample_out),
    .seg_out    (seg_out),
    .ftw_q      (ftw_q)
);

// File: tb/sim_dds_sine_gen.sv
`timescale 1ns/1ps
module sim_dds_sine_gen;
    localparam int          PW    = 24;
    localparam logic [23:0] LIMIT = 24'd6710886;

    typedef struct {
        logic [23:0] ph;
        logic [7:0]  smp;
        logic [7:0]  seg;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ftw_wr = 1'b0;
    logic [23:0] ftw_in = '0;
    logic [23:0] phase_out;
    logic [7:0]  sample_out;
    logic [7:0]  seg_out;

    int   vectors = 0;
    int   errors  = 0;
    exp_t q[$];
    logic [23:0] mph  = '0;
    logic [23:0] mftw = '0;

    always #10 clk = ~clk;

    dds_sine_gen u0 (
        .clk(clk), .rst(rst), .ftw_wr(ftw_wr), .ftw_in(ftw_in),
        .phase_out(phase_out), .sample_out(sample_out), .seg_out(seg_out)
    );

    function automatic logic [7:0] ref_sine(input logic [7:0] a);
        real v;
        v = 127.0 * $sin(6.283185307179586 * real'(a) / 256.0);
        if (v >= 0.0) return 8'(128 + $rtoi(v + 0.5));
        else          return 8'(128 - $rtoi(0.5 - v));
    endfunction

    function automatic logic [23:0] ref_clamp(input logic [23:0] w);
        return (w > LIMIT) ? LIMIT : w;
    endfunction

    task automatic step(input logic r, input logic w, input logic [23:0] word, input string tag);
        exp_t        e;
        logic [23:0] prev;
        rst = r; ftw_wr = w; ftw_in = word;
        @(posedge clk);
        prev = mph;
        if (r) begin
            mph = '0; mftw = '0;
            e.smp = 8'd128; e.seg = 8'd1;
        end else begin
            mph = mph + mftw;
            if (w) mftw = ref_clamp(word);
            e.smp = ref_sine(prev[23:16]);
            e.seg = 8'd1 << prev[23:21];
        end
        e.ph = mph; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 24'h0, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                logic bad;
                e = q.pop_front();
                vectors++;
                bad = 1'b0;
                if (phase_out !== e.ph) begin
                    bad = 1'b1;
                    $display("FAIL %s phase: got %h expected %h", e.tag, phase_out, e.ph);
                end
                if (sample_out !== e.smp) begin
                    bad = 1'b1;
                    $display("FAIL %s/R5 sample: got %0d expected %0d", e.tag, sample_out, e.smp);
                end
                if (seg_out !== e.seg) begin
                    bad = 1'b1;
                    $display("FAIL %s/R6 seg: got %b expected %b", e.tag, seg_out, e.seg);
                end
                if (bad) errors++;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 24'h0, "R1");
        run(4, "R1");                              // word zero: output holds
        step(1'b0, 1'b1, 24'h010000, "R3");        // one table slot per clock
        run(300, "R2");                            // every table entry, plus wrap
        step(1'b0, 1'b0, 24'hABCDEF, "R8");        // strobe low: ignored
        step(1'b0, 1'b0, 24'h000001, "R8");
        run(3, "R8");
        step(1'b0, 1'b1, 24'h123457, "R3");        // retune without phase reset
        run(100, "R2");
        step(1'b0, 1'b1, 24'hFFFFFF, "R4");        // above limit
        run(60, "R7");
        step(1'b0, 1'b1, LIMIT, "R4");             // exactly at limit
        run(10, "R4");
        step(1'b0, 1'b1, LIMIT + 24'd1, "R4");     // one above limit
        run(10, "R4");
        step(1'b0, 1'b1, 24'h000001, "R2");        // smallest step
        run(8, "R2");
        step(1'b0, 1'b1, 24'h0A0000, "R3");
        run(40, "R7");
        step(1'b1, 1'b0, 24'h0, "R1");             // reset mid-run
        run(5, "R1");
        step(1'b0, 1'b1, 24'h7FFFFF, "R4");
        run(20, "R7");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule